// File: doc/BRIEF.md
# Single-Wire Debug Bit Transmitter

This block is the target end of a one-pin, open-drain debug link. It returns one bit at a time to a host that runs on an unrelated clock. The host opens every bit slot by pulling the shared line low. The block passes the line through a synchronizer and decides whether the low level is a real slot start. It then counts cycles of its own clock from that perceived start and drives the pin in fixed windows that depend on the bit value. Each drive sequence ends with a one-cycle active-high speedup pulse, so the line does not have to wait for the slow rise through the pull-up resistor.

The owner offers a bit with `bit_valid` while `bit_ready` is high. The block holds that bit until the host opens a slot. It then plays the drive sequence and pulses `done` when the sequence is over. A falling edge that arrives while no bit is held is consumed and ignored. The block's own low drive and any host edge during a sequence never start a slot.

Top module: `dbgtx_top`

## Requirements
- R1: After synchronous reset, `pin_oe` = 0, `pin_out` = 0, `done` = 0 and `bit_ready` = 1.
- R2: A bit is taken on a rising edge where `bit_valid` and `bit_ready` are both 1. `bit_ready` is 0 from the next cycle until the sequence for that bit has finished.
- R3: A slot starts only if the synchronized line was high and then stays low for at least MIN_LOW (2) consecutive cycles. A low pulse of one cycle is ignored, and a loaded bit stays pending.
- R4: Slot cycle 0 is the cycle after the fourth rising edge, counting as the first edge the one where `line_in` is first sampled low (SYNC_STAGES + MIN_LOW edges). Slot cycles then advance by one per clock.
- R5: For bit value 1, the pin is driven (`pin_oe` = 1, `pin_out` = 1) only in slot cycle 7. In every other cycle of the slot the pin is released.
- R6: For bit value 0, the pin is driven low in slot cycles 0 to 12 and driven high in cycle 13. It is released from cycle 14 on.
- R7: The speedup pulse (`pin_oe` = 1 with `pin_out` = 1) lasts exactly one cycle. `pin_out` is 0 whenever `pin_oe` is 0, and `pin_oe` is 1 only during a sequence.
- R8: `done` is 1 for exactly one cycle, in slot cycle 14. `bit_ready` returns to 1 in that same cycle.
- R9: A qualified falling edge that arrives while no bit is loaded has no effect on the pins and is consumed. A line that is already low when a bit is loaded does not start a slot until the line has gone high and then low again.
- R10: Falling edges during a sequence, including those caused by the block's own low drive, never start a slot. A freshly loaded bit stays pending until the host makes a new falling edge.
- R11: A reset asserted in the middle of a sequence releases the pin at once. It also clears `done` and raises `bit_ready` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Level of the shared debug line (asynchronous) |
| bit_in | input | 1 | Bit value to send |
| bit_valid | input | 1 | Offer of `bit_in` |
| bit_ready | output | 1 | Block can accept a bit |
| pin_oe | output | 1 | Pin output enable (1 = drive) |
| pin_out | output | 1 | Pin drive value when enabled |
| done | output | 1 | One-cycle strobe after a finished sequence |

## Verification
A slot counter that is off by one moves the low window or the speedup pulse by one slot cycle. For a 0 bit this shows on `pin_oe` and `pin_out` within 14 cycles of the slot start, and for a 1 bit it shows around cycle 7. A wrong qualifier state shows up in the same slot, either as a drive sequence after a one-cycle glitch or an unloaded edge, or as no drive after a valid start. A wrong sequencer state leaves `bit_ready` or `done` wrong in cycle 14, or makes a sequence start without a host edge during the quiet windows that follow each slot.

// File: rtl/dbgtx_pkg.sv
package dbgtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOADED = 2'd1,
    ST_SEND   = 2'd2
  } tx_state_e;
endpackage

// File: rtl/dbgtx_line_qual.sv
// Synchronizes the debug line and qualifies host slot starts.
module dbgtx_line_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic mask,
  output logic start_seen
);
  localparam int LR_W = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [LR_W-1:0]        low_run;
  logic                   high_seen;
  logic                   line_s;

  assign line_s     = sync_q[SYNC_STAGES-1];
  assign start_seen = !mask && high_seen && !line_s && (low_run == LR_W'(MIN_LOW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '1;
      low_run   <= '0;
      high_seen <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      if (mask) begin
        low_run   <= '0;
        high_seen <= 1'b0;
      end else if (line_s) begin
        low_run   <= '0;
        high_seen <= 1'b1;
      end else if (start_seen) begin
        low_run   <= '0;
        high_seen <= 1'b0;
      end else if (high_seen && (low_run < LR_W'(MIN_LOW - 1))) begin
        low_run <= low_run + 1'b1;
      end
    end
  end

  // R3: a qualified start follows at least two low samples
  assert_two_low_R3: assert property (@(posedge clk) disable iff (rst)
    start_seen |-> (!line_s && $past(!line_s)));
endmodule

// File: rtl/dbgtx_bit_timer.sv
// Counts debug-clock cycles from the perceived slot start.
module dbgtx_bit_timer #(
  parameter int FRAME_LEN = 14,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             run_nxt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             finish
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign finish = run_q && (cnt_q == LAST);

  always_comb begin
    run_nxt = run_q;
    cnt_nxt = cnt_q;
    if (start) begin
      run_nxt = 1'b1;
      cnt_nxt = '0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_nxt = 1'b0;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  // R4: slot cycles advance by one per clock while running
  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && !$past(finish)) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dbgtx_drive_sched.sv
// Maps slot cycle and bit value to the pin drive pair.
module dbgtx_drive_sched #(
  parameter int CNT_W        = 4,
  parameter int SPEEDUP_ONE  = 7,
  parameter int ZERO_LOW_END = 13
) (
  input  logic             active,
  input  logic             bit_val,
  input  logic [CNT_W-1:0] cnt,
  output logic             oe,
  output logic             val
);
  always_comb begin
    oe  = 1'b0;
    val = 1'b0;
    if (active) begin
      if (bit_val) begin
        if (cnt == CNT_W'(SPEEDUP_ONE)) begin
          oe  = 1'b1;
          val = 1'b1;
        end
      end else if (cnt < CNT_W'(ZERO_LOW_END)) begin
        oe = 1'b1;
      end else if (cnt == CNT_W'(ZERO_LOW_END)) begin
        oe  = 1'b1;
        val = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbgtx_top.sv
module dbgtx_top #(
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_LOW      = 2,
  parameter int SPEEDUP_ONE  = 7,
  parameter int ZERO_LOW_END = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic bit_in,
  input  logic bit_valid,
  output logic bit_ready,
  output logic pin_oe,
  output logic pin_out,
  output logic done
);
  import dbgtx_pkg::*;

  localparam int FRAME_LEN = ZERO_LOW_END + 1;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  tx_state_e        state, state_nxt;
  logic             bit_q, bit_nxt;
  logic             qual_start, slot_start;
  logic             run_nxt, finish;
  logic [CNT_W-1:0] cnt_nxt;
  logic             oe_nxt, val_nxt;

  dbgtx_line_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst(rst), .line_in(line_in),
    .mask(state == ST_SEND), .start_seen(qual_start)
  );

  assign slot_start = qual_start && (state == ST_LOADED);

  dbgtx_bit_timer #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(slot_start),
    .run_nxt(run_nxt), .cnt_nxt(cnt_nxt), .finish(finish)
  );

  always_comb begin
    state_nxt = state;
    bit_nxt   = bit_q;
    case (state)
      ST_IDLE: if (bit_valid) begin
        state_nxt = ST_LOADED;
        bit_nxt   = bit_in;
      end
      ST_LOADED: if (slot_start) state_nxt = ST_SEND;
      ST_SEND:   if (finish) state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  dbgtx_drive_sched #(.CNT_W(CNT_W), .SPEEDUP_ONE(SPEEDUP_ONE),
                      .ZERO_LOW_END(ZERO_LOW_END)) u_sched (
    .active(run_nxt), .bit_val(bit_nxt), .cnt(cnt_nxt),
    .oe(oe_nxt), .val(val_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_q     <= 1'b0;
      pin_oe    <= 1'b0;
      pin_out   <= 1'b0;
      done      <= 1'b0;
      bit_ready <= 1'b1;
    end else begin
      state     <= state_nxt;
      bit_q     <= bit_nxt;
      pin_oe    <= oe_nxt;
      pin_out   <= val_nxt;
      done      <= finish;
      bit_ready <= (state_nxt == ST_IDLE);
    end
  end

  // R7: speedup pulse is a single cycle
  assert_speedup_single_R7: assert property (@(posedge clk) disable iff (rst)
    (pin_oe && pin_out) |=> !(pin_oe && pin_out));
  // R7: drive only while a sequence runs
  assert_oe_in_send_R7: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> (state == ST_SEND));
  // R8: done is a one-cycle strobe after a sequence
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_send_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(state == ST_SEND));
  // R9: a sequence only starts from a loaded bit
  assert_send_from_loaded_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_SEND) |-> ($past(state) == ST_LOADED));
endmodule

// File: tb/dbgtx_top_test.sv
`timescale 1ns/1ps
module dbgtx_top_test;
  localparam int LAT = 4;  // negedges from line fall to slot cycle 0

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_low = 1'b0;
  logic bit_in = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_ready, pin_oe, pin_out, done;
  logic line_in;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign line_in = pin_oe ? pin_out : ~host_low;

  dbgtx_top uut (
    .clk(clk), .rst(rst), .line_in(line_in), .bit_in(bit_in),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .pin_oe(pin_oe),
    .pin_out(pin_out), .done(done)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual={oe,out,done,rdy}=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_slot(input logic b, input int c);
    logic oe, out;
    if (b) begin
      oe = (c == 7); out = (c == 7);
    end else begin
      oe = (c <= 13); out = (c == 13);
    end
    return {oe, out, (c == 14) ? 1'b1 : 1'b0, (c >= 14) ? 1'b1 : 1'b0};
  endfunction

  task automatic load(input logic b);
    @(negedge clk);
    chk("R2 ready before load", {pin_oe, pin_out, done, bit_ready}, 4'b0001);
    bit_in = b; bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    chk("R2 ready drops after load", {pin_oe, pin_out, done, bit_ready}, 4'b0000);
  endtask

  // host opens a slot, holding low for hold negedges; optional extra pulse at slot cycle glitch
  task automatic fire(input logic b, input int hold, input int glitch, input string req);
    @(negedge clk);
    host_low = 1'b1;
    for (int k = 1; k <= LAT + 16; k++) begin
      @(negedge clk);
      if (k >= LAT && k - LAT <= 15)
        chk(req, {pin_oe, pin_out, done, bit_ready}, exp_slot(b, k - LAT));
      if (k == hold) host_low = 1'b0;
      if (glitch >= 0 && k == LAT + glitch) host_low = 1'b1;
      if (glitch >= 0 && k == LAT + glitch + 2) host_low = 1'b0;
    end
  endtask

  task automatic quiet(input int n, input logic rdy, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, {pin_oe, pin_out, done, bit_ready}, {3'b000, rdy});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", {pin_oe, pin_out, done, bit_ready}, 4'b0001);

    // R4 R5 R6 R7 R8: sweep bit value and host hold length
    for (int h = 2; h <= 5; h++) begin
      for (int b = 0; b < 2; b++) begin
        load(b[0]);
        fire(b[0], h, -1, b[0] ? "R5 R7 R8 bit one slot" : "R6 R7 R8 bit zero slot");
      end
    end

    // R3: one-cycle glitch ignored, bit stays pending, then min-length start works
    load(1'b1);
    @(negedge clk); host_low = 1'b1;
    @(negedge clk); host_low = 1'b0;
    quiet(20, 1'b0, "R3 short pulse ignored");
    fire(1'b1, 2, -1, "R3 two-cycle low accepted");

    // R9: edge with nothing loaded is ignored
    @(negedge clk); host_low = 1'b1;
    repeat (3) @(negedge clk);
    host_low = 1'b0;
    quiet(20, 1'b1, "R9 unloaded edge ignored");
    // R9: line already low while loading does not start
    @(negedge clk); host_low = 1'b1;
    repeat (4) @(negedge clk);
    load(1'b0);
    quiet(10, 1'b0, "R9 held low no start");
    host_low = 1'b0;
    quiet(3, 1'b0, "R9 release no start");
    fire(1'b0, 2, -1, "R9 fresh edge starts");

    // R10: host edge during a sequence and own low drive never start a slot
    load(1'b1);
    fire(1'b1, 2, 9, "R10 bit one with host edge mid-slot");
    load(1'b0);
    quiet(25, 1'b0, "R10 no start after mid-slot edge");
    fire(1'b0, 3, -1, "R10 bit zero slot");
    load(1'b1);
    quiet(25, 1'b0, "R10 own drive not a start");
    fire(1'b1, 2, -1, "R10 next slot after quiet");

    // R11: reset in the middle of a sequence
    load(1'b0);
    @(negedge clk); host_low = 1'b1;
    for (int k = 1; k <= LAT + 5; k++) begin
      @(negedge clk);
      if (k == 2) host_low = 1'b0;
    end
    chk("R11 driving before reset", {pin_oe, pin_out, done, bit_ready}, 4'b1000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 released after reset", {pin_oe, pin_out, done, bit_ready}, 4'b0001);
    quiet(5, 1'b1, "R11 idle after reset");
    load(1'b0);
    fire(1'b0, 2, -1, "R11 slot after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule